// File: doc/BRIEF.md
# SPI Receive Frame Validator

This block sits on the receive side of a device register interface. While chip select is held low it shifts serial data in, most significant bit first, on each rising edge of the serial clock, and counts the bits. When chip select returns high it judges the frame. A frame is valid only if it holds exactly 16 bits and the XOR of all 16 bits is one (odd parity), with bit 0 as the parity bit. A valid frame produces a one-cycle write strobe that carries the 15 payload bits to the register file. An invalid frame produces no write, clears the receive shift register to all zeros, and sets a sticky error flag: a length flag for a wrong bit count, or a parity flag when the count is right but the parity is wrong. The parity flag tells software to rewrite its whole configuration.

All inputs are already synchronized to the system clock. The serial clock, chip select and data are sampled on the system clock, and the edges are found by comparison with the previous sample. A controller with three states drives the work. ST_IDLE waits with chip select high and goes to ST_SHIFT on the chip-select falling edge. ST_SHIFT takes in bits and goes to ST_CHECK on the chip-select rising edge. ST_CHECK judges the frame for one cycle, then goes back to ST_IDLE, or straight to ST_SHIFT if chip select has fallen again. The parity result is computed only in ST_CHECK, so it has no effect while a frame is being received.

Top module: `spi_frame_validator`

## Requirements
- R1: After reset, wr_stb_o is 0, par_err_o and len_err_o are 0, and rx_word_o is 0.
- R2: While chip select is low, each serial clock rising edge shifts mosi_i into bit 0 of rx_word_o, moving earlier bits toward the MSB. After a valid frame, rx_word_o holds the 16 received bits, with the first bit received in bit 15.
- R3: For a frame of exactly 16 bits whose XOR is 1, wr_stb_o is high for exactly one clock cycle after the chip-select rising edge. During that cycle wr_data_o equals bits 15..1 of the frame.
- R4: A frame whose bit count is not 16 produces no strobe, sets len_err_o and clears rx_word_o to 0. This includes a frame with zero bits and a frame with more than 16 bits: the counter saturates at 17, so a count far above 16 cannot wrap back to 16.
- R5: A 16-bit frame whose XOR is 0 produces no strobe, sets par_err_o and clears rx_word_o to 0.
- R6: Each error flag stays set until the next valid frame, which clears both flags. A length error leaves par_err_o unchanged, and a parity error leaves len_err_o unchanged.
- R7: While chip select is low, par_err_o, len_err_o and wr_stb_o do not change.
- R8: Serial clock edges while chip select is high have no effect on rx_word_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Synchronized serial clock |
| csn_i | input | 1 | Synchronized chip select, active low |
| mosi_i | input | 1 | Synchronized serial data in |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_data_o | output | 15 | Payload bits 15..1 of the accepted frame |
| par_err_o | output | 1 | Sticky parity error flag |
| len_err_o | output | 1 | Sticky frame length error flag |
| rx_word_o | output | 16 | Receive shift register contents |

## Verification
The bench sends frames of 15 and 17 bits to catch an off-by-one in the length compare, which would write a truncated or shifted payload. It sends a 40-bit frame to catch a counter that wraps instead of saturating, which would accept a frame whose count wraps back to 16. It sends parity-bad frames to catch an even-parity check, or a missing clear of the shift register, which would leave stale data visible. It checks the flags in the middle of a frame and across mixed sequences of errors, to catch flags that clear too early, flags that clear each other, and parity that is evaluated while chip select is low.

// File: rtl/sfv_pkg.sv
package sfv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CHECK = 2'd2
    } sfv_state_e;
endpackage

// File: rtl/sfv_edge.sv
module sfv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic csn,
    output logic sclk_rise,
    output logic cs_fall,
    output logic cs_rise
);
    logic sclk_d;
    logic csn_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk;
            csn_d  <= csn;
        end
    end

    assign sclk_rise = sclk & ~sclk_d;
    assign cs_fall   = ~csn & csn_d;
    assign cs_rise   = csn & ~csn_d;
endmodule

// File: rtl/sfv_shift.sv
module sfv_shift #(
    parameter int FRAME_BITS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          shift_en,
    input  logic                          clr,
    input  logic                          din,
    output logic [FRAME_BITS-1:0]         shreg,
    output logic [$clog2(FRAME_BITS+2)-1:0] cnt
);
    localparam int CW  = $clog2(FRAME_BITS + 2);
    localparam int SAT = FRAME_BITS + 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (clr) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[FRAME_BITS-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (shift_en && (cnt != CW'(SAT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the bit counter never exceeds its saturation value
    assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(SAT));
endmodule

// File: rtl/sfv_ctrl.sv
module sfv_ctrl
    import sfv_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sclk_rise,
    input  logic                            cs_fall,
    input  logic                            cs_rise,
    input  logic [FRAME_BITS-1:0]           shreg,
    input  logic [$clog2(FRAME_BITS+2)-1:0] cnt,
    output logic                            start,
    output logic                            shift_en,
    output logic                            clr,
    output logic                            wr_stb,
    output logic [FRAME_BITS-2:0]           wr_data,
    output logic                            par_err,
    output logic                            len_err
);
    localparam int CW = $clog2(FRAME_BITS + 2);

    sfv_state_e state, state_nx;
    logic len_ok;
    logic par_ok;
    logic frame_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT: if (cs_rise) state_nx = ST_CHECK;
            ST_CHECK: state_nx = cs_fall ? ST_SHIFT : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // parity is only looked at once chip select has returned high
    assign len_ok   = (state == ST_CHECK) && (cnt == CW'(FRAME_BITS));
    assign par_ok   = (state == ST_CHECK) && (^shreg);
    assign frame_ok = len_ok && par_ok;

    assign start    = cs_fall;
    assign shift_en = (state == ST_SHIFT) && sclk_rise;
    assign clr      = (state == ST_CHECK) && !frame_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_data <= '0;
            par_err <= 1'b0;
            len_err <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (state == ST_CHECK) begin
                if (frame_ok) begin
                    wr_stb  <= 1'b1;
                    wr_data <= shreg[FRAME_BITS-1:1];
                    par_err <= 1'b0;
                    len_err <= 1'b0;
                end else if (!len_ok) begin
                    len_err <= 1'b1;
                end else begin
                    par_err <= 1'b1;
                end
            end
        end
    end

    // R3: strobe is a single-cycle pulse following the check state
    assert_stb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    assert_stb_after_check_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(state) == ST_CHECK);
    // R4 / R5: an error being raised coincides with a cleared shift register
    assert_len_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(len_err) |-> shreg == '0);
    assert_par_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> shreg == '0);
    // R7: flags and strobe frozen while a frame is being received
    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_SHIFT) |->
            ($stable(par_err) && $stable(len_err) && !wr_stb));
    // R8: idle state leaves the shift register untouched
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(shreg));
endmodule

// File: rtl/spi_frame_validator.sv
module spi_frame_validator #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_i,
    input  logic                  csn_i,
    input  logic                  mosi_i,
    output logic                  wr_stb_o,
    output logic [FRAME_BITS-2:0] wr_data_o,
    output logic                  par_err_o,
    output logic                  len_err_o,
    output logic [FRAME_BITS-1:0] rx_word_o
);
    localparam int CW = $clog2(FRAME_BITS + 2);

    logic          sclk_rise, cs_fall, cs_rise;
    logic          start, shift_en, clr;
    logic [CW-1:0] cnt;

    sfv_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk_i),
        .csn       (csn_i),
        .sclk_rise (sclk_rise),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise)
    );

    sfv_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .shift_en (shift_en),
        .clr      (clr),
        .din      (mosi_i),
        .shreg    (rx_word_o),
        .cnt      (cnt)
    );

    sfv_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .shreg     (rx_word_o),
        .cnt       (cnt),
        .start     (start),
        .shift_en  (shift_en),
        .clr       (clr),
        .wr_stb    (wr_stb_o),
        .wr_data   (wr_data_o),
        .par_err   (par_err_o),
        .len_err   (len_err_o)
    );

    // R6: both flags drop together, only on an accepted frame
    assert_flags_clear_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(par_err_o) || $fell(len_err_o)) |-> wr_stb_o);
endmodule

// File: tb/test_spi_frame_validator.sv
module test_spi_frame_validator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        csn = 1'b1;
    logic        mosi = 1'b0;
    logic        wr_stb;
    logic [14:0] wr_data;
    logic        par_err, len_err;
    logic [15:0] rx_word;

    int checks = 0;
    int failures = 0;
    logic [14:0] exp_q[$];
    logic exp_par = 1'b0;
    logic exp_len = 1'b0;
    logic [15:0] exp_word = '0;

    always #10 clk = ~clk;

    spi_frame_validator i_spi_frame_validator (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
        .wr_stb_o(wr_stb), .wr_data_o(wr_data), .par_err_o(par_err),
        .len_err_o(len_err), .rx_word_o(rx_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every strobe must match the next expected payload (R3)
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R3 actual=%0h expected=no strobe", wr_data);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                if (wr_data !== e) begin
                    failures++;
                    $display("FAIL R3 actual=%0h expected=%0h", wr_data, e);
                end
            end
        end
    end

    function automatic logic [15:0] good(input logic [14:0] p);
        return {p, ~(^p)};
    endfunction

    function automatic logic [15:0] bad(input logic [14:0] p);
        return {p, ^p};
    endfunction

    task automatic clk_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: sends n bits MSB first and predicts the outcome
    task automatic send(input logic [63:0] d, input int n);
        logic ok;
        ok = (n == 16) && (^d[15:0]);
        @(negedge clk); csn = 1'b0;
        clk_wait(3);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = d[i];
            clk_wait(2); sclk = 1'b1;
            clk_wait(2); sclk = 1'b0;
            if (i == n / 2) begin
                check("R7 par_err mid-frame", par_err, exp_par);
                check("R7 len_err mid-frame", len_err, exp_len);
            end
        end
        clk_wait(3);
        if (ok) begin
            exp_q.push_back(d[15:1]);
            exp_word = d[15:0];
            exp_par = 1'b0;
            exp_len = 1'b0;
        end else begin
            exp_word = '0;
            if (n != 16) exp_len = 1'b1;
            else         exp_par = 1'b1;
        end
        csn = 1'b1;
        clk_wait(5);
        check("R4/R5 rx_word after frame", rx_word, exp_word);
        check("R6 par_err after frame", par_err, exp_par);
        check("R6 len_err after frame", len_err, exp_len);
        check("R3 no pending strobe", exp_q.size(), 0);
    endtask

    initial begin
        #(20ns * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clk_wait(3);
        check("R1 wr_stb", wr_stb, 0);
        check("R1 par_err", par_err, 0);
        check("R1 len_err", len_err, 0);
        check("R1 rx_word", rx_word, 0);
        rst_n = 1'b1;
        clk_wait(3);

        // R2 R3: valid frames, payload and ordering
        send(64'(good(15'h1234)), 16);
        check("R2 rx_word holds frame", rx_word, good(15'h1234));
        send(64'(good(15'h7FFF)), 16);
        send(64'(good(15'h0000)), 16);

        // R8: serial clock toggling with chip select high
        for (int k = 0; k < 4; k++) begin
            mosi = 1'b1; clk_wait(2); sclk = 1'b1; clk_wait(2); sclk = 1'b0;
        end
        clk_wait(2);
        check("R8 rx_word unchanged", rx_word, good(15'h0000));

        // R5: parity error
        send(64'(bad(15'h2AAA)), 16);
        // R4 with R6: length error leaves par_err set
        send(64'h1FFFF, 15);
        send(64'(good(15'h0F0F)) << 1 | 64'h1, 17);
        send(64'h0, 0);
        send(64'hAB_CDEF_0123, 40);
        // R6: valid frame clears both
        send(64'(good(15'h5555)), 16);
        // R6: length then parity error, then clear
        send(64'h3, 2);
        send(64'(bad(15'h0001)), 16);
        send(64'(good(15'h4321)), 16);

        clk_wait(4);
        check("R3 queue drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule